// File: doc/BRIEF.md
# Paged Program Counter and Fetch Sequencer

This block holds the program counter of a small two-stage microcontroller pipeline in which the next instruction word is fetched while the current one executes. Every cycle it presents a fetch address to program memory and tells the execute stage whether the word now executing is a real instruction or a dummy bubble. The decoder drives it with control strobes: an absolute load (jump or call) with its target, a forced interrupt-vector load, a write of the counter's low byte from the data path, and a skip request with its condition.

Any event that makes the already-fetched word wrong costs exactly one bubble. That word is marked invalid, and the correct one is fetched in the same cycle. A low-byte write changes only bits 7:0 and keeps the page bits above them, so it acts as a jump inside the current 256-word page. The low byte of the counter is always available for reading. The stack, the decoder and the program memory sit outside this block.

Top module: `pc_fetch_seq`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the counter becomes 0 and `exec_valid` becomes 0. On the first edge after release, the counter becomes 1 and `exec_valid` becomes 1, because the word fetched from address 0 is then executing.
- R2: In a valid cycle with no strobe active, the counter advances by one at the next edge and `exec_valid` stays 1. The counter wraps from its maximum value (all PC_W bits set) to 0.
- R3: In a valid cycle, `jump_en` loads `target` into all PC_W counter bits and sets `exec_valid` to 0 for exactly one cycle. The instruction therefore spends two cycles.
- R4: `irq_en` loads the parameter IRQ_VEC and sets `exec_valid` to 0. It acts in any cycle, including a bubble cycle, and takes priority over every other strobe.
- R5: In a valid cycle, `pcl_wr` replaces counter bits 7:0 with `pcl_wdata` and keeps bits PC_W-1:8 of the current counter. `exec_valid` is 0 for the next cycle only.
- R6: In a valid cycle, `skip_req` with `skip_cond` = 1 lets the counter advance by one but sets `exec_valid` to 0, which discards the prefetched word. With `skip_cond` = 0 the cycle behaves as in R2.
- R7: Priority among strobes in a valid cycle runs from highest to lowest: `irq_en`, `jump_en`, `pcl_wr`, satisfied skip. When `pcl_wr` and a satisfied skip coincide, the result is the R5 page jump with a single bubble.
- R8: In a bubble cycle (`exec_valid` = 0), `jump_en`, `pcl_wr` and `skip_req` have no effect. The counter advances by one and `exec_valid` returns to 1.
- R9: `pcl_rd` always equals bits 7:0 of `fetch_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_en | input | 1 | Force a load of the interrupt vector |
| jump_en | input | 1 | Absolute load of `target` (jump or call) |
| target | input | PC_W | Absolute destination address |
| pcl_wr | input | 1 | Write the low byte of the counter |
| pcl_wdata | input | 8 | New low byte |
| skip_req | input | 1 | A conditional skip is executing |
| skip_cond | input | 1 | The skip condition holds |
| fetch_addr | output | PC_W | Program memory address fetched this cycle |
| exec_valid | output | 1 | The executing word is a real instruction |
| pcl_rd | output | 8 | Readable low byte of the counter |

## Verification
A wrong counter value appears on `fetch_addr` and `pcl_rd` at the very next clock edge, and every later address inherits the error, so a comparison every cycle localises it to one edge. A wrong bubble flag shows on `exec_valid` in the same one-cycle window. It is also exposed one cycle later, because a strobe that should have been ignored, or should have taken effect, changes the address. The bench sweeps every jump target and every low-byte value across every page, adds a long stretch of mixed strobes that includes collisions and strobes inside bubbles, and compares each cycle with an arithmetic model.

// File: rtl/pcf_pkg.sv
// Shared types for the fetch sequencer.
// Assumes nothing beyond a synthesizable enum encoding.
package pcf_pkg;

    // Next-counter action, chosen once per cycle by the arbiter.
    typedef enum logic [2:0] {
        ACT_STEP,    // sequential advance, next word valid
        ACT_REFILL,  // bubble cycle: advance, next word valid again
        ACT_SKIP,    // satisfied skip: advance, discard prefetched word
        ACT_PAGE,    // low-byte write: in-page jump
        ACT_LOAD,    // absolute jump or call
        ACT_VECTOR   // interrupt vector load
    } pcf_act_e;

endpackage

// File: rtl/pcf_arbiter.sv
// Picks one action per cycle from the decoder strobes.
// Assumes the strobes come from decoding the executing word. In a bubble
// cycle that word is a dummy, so only the interrupt strobe is honoured.
module pcf_arbiter
    import pcf_pkg::*;
(
    input  logic     exec_valid,
    input  logic     irq_en,
    input  logic     jump_en,
    input  logic     pcl_wr,
    input  logic     skip_req,
    input  logic     skip_cond,
    output pcf_act_e act
);

    // Fixed priority: interrupt, bubble refill, jump, low-byte write, skip.
    always_comb begin
        if (irq_en)
            act = ACT_VECTOR;
        else if (!exec_valid)
            act = ACT_REFILL;
        else if (jump_en)
            act = ACT_LOAD;
        else if (pcl_wr)
            act = ACT_PAGE;
        else if (skip_req && skip_cond)
            act = ACT_SKIP;
        else
            act = ACT_STEP;
    end

endmodule

// File: rtl/pcf_next_addr.sv
// Computes the next counter value and the next valid flag from the action.
// Assumes PC_W >= 8. The in-page target keeps the counter's own upper bits.
module pcf_next_addr
    import pcf_pkg::*;
#(
    parameter int              PC_W    = 10,
    parameter logic [PC_W-1:0] IRQ_VEC = '0
) (
    input  pcf_act_e        act,
    input  logic [PC_W-1:0] pc,
    input  logic [PC_W-1:0] target,
    input  logic [7:0]      pcl_wdata,
    output logic [PC_W-1:0] pc_next,
    output logic            valid_next
);

    localparam logic [PC_W-1:0] PC_ONE = 1;

    logic [PC_W-1:0] pc_inc;
    logic [PC_W-1:0] page_tgt;

    // Sequential successor, wrapping modulo 2**PC_W.
    assign pc_inc = pc + PC_ONE;

    // In-page target: a wide counter keeps its page bits, an 8-bit one has none.
    generate
        if (PC_W > 8) begin : g_paged
            assign page_tgt = {pc[PC_W-1:8], pcl_wdata};
        end else begin : g_flat
            assign page_tgt = pcl_wdata;
        end
    endgenerate

    // Address and valid-flag selection per action.
    always_comb begin
        pc_next    = pc_inc;
        valid_next = 1'b1;
        unique case (act)
            ACT_STEP:   begin pc_next = pc_inc;   valid_next = 1'b1; end
            ACT_REFILL: begin pc_next = pc_inc;   valid_next = 1'b1; end
            ACT_SKIP:   begin pc_next = pc_inc;   valid_next = 1'b0; end
            ACT_PAGE:   begin pc_next = page_tgt; valid_next = 1'b0; end
            ACT_LOAD:   begin pc_next = target;   valid_next = 1'b0; end
            ACT_VECTOR: begin pc_next = IRQ_VEC;  valid_next = 1'b0; end
            default:    begin pc_next = pc_inc;   valid_next = 1'b1; end
        endcase
    end

endmodule

// File: rtl/pcf_state.sv
// Holds the counter and the executing-word valid flag.
// Assumes a synchronous active-low reset. Reset forces RESET_ADDR and a bubble.
module pcf_state #(
    parameter int              PC_W       = 10,
    parameter logic [PC_W-1:0] RESET_ADDR = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] pc_next,
    input  logic            valid_next,
    output logic [PC_W-1:0] pc,
    output logic            exec_valid
);

    // Counter and valid-flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc         <= RESET_ADDR;
            exec_valid <= 1'b0;
        end else begin
            pc         <= pc_next;
            exec_valid <= valid_next;
        end
    end

endmodule

// File: rtl/pc_fetch_seq.sv
// Program counter and fetch sequencer for a two-stage fetch/execute pipeline.
// Assumes the decoder's strobes describe the word that is executing now, and
// that program memory returns the word at fetch_addr for the next cycle.
module pc_fetch_seq
    import pcf_pkg::*;
#(
    parameter int              PC_W    = 10,
    parameter logic [PC_W-1:0] IRQ_VEC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            irq_en,
    input  logic            jump_en,
    input  logic [PC_W-1:0] target,
    input  logic            pcl_wr,
    input  logic [7:0]      pcl_wdata,
    input  logic            skip_req,
    input  logic            skip_cond,
    output logic [PC_W-1:0] fetch_addr,
    output logic            exec_valid,
    output logic [7:0]      pcl_rd
);

    pcf_act_e        act;
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_next;
    logic            valid_q;
    logic            valid_next;

    pcf_arbiter u_arb (
        .exec_valid (valid_q),
        .irq_en     (irq_en),
        .jump_en    (jump_en),
        .pcl_wr     (pcl_wr),
        .skip_req   (skip_req),
        .skip_cond  (skip_cond),
        .act        (act)
    );

    pcf_next_addr #(.PC_W(PC_W), .IRQ_VEC(IRQ_VEC)) u_next (
        .act        (act),
        .pc         (pc_q),
        .target     (target),
        .pcl_wdata  (pcl_wdata),
        .pc_next    (pc_next),
        .valid_next (valid_next)
    );

    pcf_state #(.PC_W(PC_W), .RESET_ADDR('0)) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .pc_next    (pc_next),
        .valid_next (valid_next),
        .pc         (pc_q),
        .exec_valid (valid_q)
    );

    // Outputs come straight from the state registers.
    assign fetch_addr = pc_q;
    assign exec_valid = valid_q;
    assign pcl_rd     = pc_q[7:0];

endmodule

// File: rtl/pc_fetch_seq_chk.sv
// Port-level temporal checks for pc_fetch_seq, bound to every instance.
// Assumes the synchronous active-low reset on rst_n.
module pc_fetch_seq_chk #(
    parameter int              PC_W    = 10,
    parameter logic [PC_W-1:0] IRQ_VEC = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            irq_en,
    input logic            jump_en,
    input logic [PC_W-1:0] target,
    input logic            pcl_wr,
    input logic [7:0]      pcl_wdata,
    input logic            skip_req,
    input logic            skip_cond,
    input logic [PC_W-1:0] fetch_addr,
    input logic            exec_valid
);

    localparam logic [PC_W-1:0] ONE = 1;

    AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && !irq_en && !jump_en && !pcl_wr && !(skip_req && skip_cond))
        |=> (fetch_addr == $past(fetch_addr) + ONE) && exec_valid); // R2

    AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && jump_en && !irq_en)
        |=> (fetch_addr == $past(target)) && !exec_valid); // R3

    AST_VECTOR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        irq_en |=> (fetch_addr == IRQ_VEC) && !exec_valid); // R4

    AST_PAGE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && pcl_wr && !jump_en && !irq_en)
        |=> (fetch_addr[7:0] == $past(pcl_wdata)) && !exec_valid
            && (fetch_addr[PC_W-1:8] == $past(fetch_addr[PC_W-1:8]))); // R5

    AST_SKIP_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && skip_req && skip_cond && !pcl_wr && !jump_en && !irq_en)
        |=> (fetch_addr == $past(fetch_addr) + ONE) && !exec_valid); // R6

    AST_BUBBLE_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (!exec_valid && !irq_en)
        |=> (fetch_addr == $past(fetch_addr) + ONE) && exec_valid); // R8

endmodule

bind pc_fetch_seq pc_fetch_seq_chk #(.PC_W(PC_W), .IRQ_VEC(IRQ_VEC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_en     (irq_en),
    .jump_en    (jump_en),
    .target     (target),
    .pcl_wr     (pcl_wr),
    .pcl_wdata  (pcl_wdata),
    .skip_req   (skip_req),
    .skip_cond  (skip_cond),
    .fetch_addr (fetch_addr),
    .exec_valid (exec_valid)
);

// File: tb/pc_fetch_seq_test.sv
// Self-checking bench: directed sweeps plus a long mixed-strobe run,
// compared every cycle against an arithmetic model built from the requirements.
module pc_fetch_seq_test;

    localparam int              PC_W = 10;
    localparam logic [PC_W-1:0] VEC  = 10'h004;
    localparam int              NADR = 1 << PC_W;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            irq_en, jump_en, pcl_wr, skip_req, skip_cond;
    logic [PC_W-1:0] target;
    logic [7:0]      pcl_wdata;
    logic [PC_W-1:0] fetch_addr;
    logic            exec_valid;
    logic [7:0]      pcl_rd;

    always #5 clk = ~clk;

    pc_fetch_seq #(.PC_W(PC_W), .IRQ_VEC(VEC)) uut (
        .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .jump_en(jump_en),
        .target(target), .pcl_wr(pcl_wr), .pcl_wdata(pcl_wdata),
        .skip_req(skip_req), .skip_cond(skip_cond),
        .fetch_addr(fetch_addr), .exec_valid(exec_valid), .pcl_rd(pcl_rd)
    );

    int              n_tests = 0;
    int              n_fail  = 0;
    bit              finished = 0;
    logic [PC_W-1:0] m_pc;
    logic            m_v;
    bit              m_in_rst;
    logic [15:0]     lfsr = 16'hACE1;

    // Compare ports with the model after the edge has settled.
    task automatic check(input string tag);
        n_tests++;
        if (fetch_addr !== m_pc || exec_valid !== m_v) begin
            n_fail++;
            $display("FAIL %s: addr=%h valid=%b expected addr=%h valid=%b",
                     tag, fetch_addr, exec_valid, m_pc, m_v);
        end
        n_tests++;
        if (pcl_rd !== m_pc[7:0]) begin
            n_fail++;
            $display("FAIL R9: pcl_rd=%h expected %h", pcl_rd, m_pc[7:0]);
        end
    endtask

    // Drive one cycle of inputs at a falling edge, advance the model, check at the next falling edge.
    task automatic step(input logic r, input logic irq, input logic jmp,
                        input logic pw, input logic sk, input logic sc,
                        input logic [PC_W-1:0] tgt, input logic [7:0] wd);
        string tag;
        rst_n = r; irq_en = irq; jump_en = jmp; pcl_wr = pw;
        skip_req = sk; skip_cond = sc; target = tgt; pcl_wdata = wd;
        if (!r) begin
            m_pc = '0; m_v = 1'b0; tag = "R1"; m_in_rst = 1;
        end else if (irq) begin
            m_pc = VEC; m_v = 1'b0; tag = "R4"; m_in_rst = 0;
        end else if (!m_v) begin
            m_pc = m_pc + 1'b1; m_v = 1'b1;
            tag = m_in_rst ? "R1" : "R8"; m_in_rst = 0;
        end else if (jmp) begin
            m_pc = tgt; m_v = 1'b0; tag = (pw || sk) ? "R7" : "R3";
        end else if (pw) begin
            m_pc = {m_pc[PC_W-1:8], wd}; m_v = 1'b0; tag = sk ? "R7" : "R5";
        end else if (sk && sc) begin
            m_pc = m_pc + 1'b1; m_v = 1'b0; tag = "R6";
        end else begin
            m_pc = m_pc + 1'b1; m_v = 1'b1; tag = sk ? "R6" : "R2";
        end
        @(negedge clk);
        check(tag);
    endtask

    task automatic idle();
        step(1, 0, 0, 0, 0, 0, '0, 8'h00);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run not done, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        m_pc = '0; m_v = 1'b0; m_in_rst = 1;
        rst_n = 0; irq_en = 0; jump_en = 0; pcl_wr = 0;
        skip_req = 0; skip_cond = 0; target = '0; pcl_wdata = '0;
        @(negedge clk);
        // R1: reset state, then release and first valid word
        step(0, 0, 0, 0, 0, 0, '0, 8'h00);
        step(0, 1, 1, 1, 1, 1, 10'h155, 8'h77);
        idle();
        repeat (4) idle();                                   // R2 sequential run

        // R3: every jump target, each followed by its bubble recovery
        for (int t = 0; t < NADR; t++) begin
            step(1, 0, 1, 0, 0, 0, PC_W'(t), 8'h00);
            idle();
        end

        // R2: wrap from the top address
        step(1, 0, 1, 0, 0, 0, 10'h3FE, 8'h00);
        repeat (4) idle();

        // R5: every low byte in every page, from a mid-page start
        for (int p = 0; p < (NADR >> 8); p++) begin
            for (int w = 0; w < 256; w++) begin
                step(1, 0, 1, 0, 0, 0, PC_W'((p << 8) | 8'h80), 8'h00);
                idle();
                step(1, 0, 0, 1, 0, 0, '0, 8'(w));
                idle();
            end
        end

        // R6: satisfied and unsatisfied skips
        for (int k = 0; k < 8; k++) begin
            step(1, 0, 0, 0, 1, k[0], '0, 8'h00);
            idle();
        end

        // R7: collisions of strobes in a valid cycle
        step(1, 0, 0, 1, 1, 1, '0, 8'h3C);
        idle();
        step(1, 0, 1, 1, 0, 0, 10'h2A0, 8'h11);
        idle();
        step(1, 0, 1, 0, 1, 1, 10'h1F0, 8'h00);
        idle();

        // R8: strobes inside a bubble have no effect
        step(1, 0, 1, 0, 0, 0, 10'h100, 8'h00);
        step(1, 0, 1, 0, 0, 0, 10'h300, 8'h00);
        step(1, 0, 1, 0, 0, 0, 10'h0C0, 8'h00);
        step(1, 0, 0, 1, 1, 1, '0, 8'hEE);
        idle();

        // R4: vector from a valid cycle, from a bubble, and against a jump
        step(1, 1, 0, 0, 0, 0, '0, 8'h00);
        step(1, 1, 1, 1, 1, 1, 10'h333, 8'h99);
        idle();
        step(1, 1, 1, 0, 0, 0, 10'h222, 8'h00);
        idle();

        // R1: reset in the middle of a run
        step(0, 0, 0, 0, 0, 0, '0, 8'h00);
        idle();

        // Mixed strobes, all requirements
        for (int i = 0; i < 20000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step((lfsr[15:10] != 6'h00), (lfsr[9:6] == 4'h0), (lfsr[5:3] == 3'h0),
                 (lfsr[2:0] == 3'h1), lfsr[11], lfsr[8],
                 PC_W'({lfsr[7:0], lfsr[13:12]}), {lfsr[4:0], lfsr[14:12]});
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule